// File: doc/BRIEF.md
# I2C Master Bit-Timing Generator

This block produces the line timing for a single-master I2C bus from one system clock. Two chained clock-enable prescalers set the length of a quarter-bit phase. A 4-bit code selects the first divisor, and a 3-bit code selects a power-of-two second divisor. Every bus bit is built from four equal phases. During these phases the block drives SCL through a push-pull output with its own enable, and it changes the SDA direction at fixed phase points. It never looks at the bus to decide when to do this.

A byte-level controller feeds the block one bit command at a time: start condition, stop condition, write a data bit, or read a data bit. The block reports the end of each quarter phase and the end of each bit. A read bit returns the SDA value sampled while SCL was high. Between bits inside a transaction the block holds SCL low and releases SDA. After a stop, the bus is free and both lines are released.

Top module: `i2cq_bitgen`

## Requirements
- R1: One phase lasts A*B system clock cycles. A is the first-stage divisor: 2, 4 or 8 for codes 0, 1 or 2, and four times the code for codes 3 to 15. B is the second-stage divisor. Counted from the accepting edge to the bit_done cycle inclusive, a bit lasts 4*A*B cycles.
- R2: The second-stage divisor B equals 4 shifted left by the 3-bit code, so codes 0 to 7 give 4 to 512.
- R3: During an active bit, scl_oe is 1. For start, write and read bits, scl_out is 0 in phases 0 and 3 and 1 in phases 1 and 2. For a stop bit, scl_out is 0 in phase 0 and 1 in phases 1 to 3.
- R4: When the bus is free (after reset, after a completed stop, or after an abort), scl_oe, scl_out, sda_oe and sda_out are all 0.
- R5: When no bit is active after a start has been accepted and before its stop completes, scl_oe is 1, scl_out is 0, and sda_oe and sda_out are 0.
- R6: A write bit (cmd_kind 2) drives sda_oe=1 and sda_out=cmd_bit for the whole bit. A read bit (cmd_kind 3) keeps sda_oe=0, samples sda_in at the end of phase 2, and presents that value on rx_bit during the bit_done cycle. rx_bit is 0 at all other times.
- R7: A start (cmd_kind 0) drives sda_oe=1 with sda_out 1 in phases 0 and 1 and 0 in phases 2 and 3. A stop (cmd_kind 1) drives sda_oe=1 with sda_out 0 in phases 0 and 1 and 1 in phases 2 and 3.
- R8: phase_strobe[k] is high for exactly one cycle, the last cycle of phase k. bit_done equals phase_strobe[3].
- R9: The divisor codes are captured when a command is accepted. Changing them during a bit has no effect on that bit, and the next bit uses the new codes.
- R10: cmd_ready is en AND no active bit. A command is taken on a clock edge where cmd_valid and cmd_ready are both 1. Dropping en aborts any bit and transaction, which returns the bus to the free state on the next cycle.
- R11: While rst is high, all outputs are 0 except cmd_ready, which follows en once no bit is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Block enable; low aborts and frees the bus |
| nf_code | input | 4 | First-stage divisor code |
| scl_code | input | 3 | Second-stage divisor code |
| cmd_valid | input | 1 | Bit command present |
| cmd_kind | input | 2 | 0 start, 1 stop, 2 write, 3 read |
| cmd_bit | input | 1 | Data value for a write bit |
| cmd_ready | output | 1 | Block can take a command this cycle |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | SCL driver enable |
| scl_out | output | 1 | SCL driven level |
| sda_oe | output | 1 | SDA driver enable |
| sda_out | output | 1 | SDA driven level |
| phase_strobe | output | 4 | One-cycle end-of-phase pulses, bit k for phase k |
| bit_done | output | 1 | End of the current bit |
| rx_bit | output | 1 | Sampled read value, valid with bit_done |

## Verification
The hardest cases to reach from the ports are a divisor code change that lands inside a running bit and an abort in the middle of a bit. The stimulus for the code change waits for the command to be accepted and then changes both codes on the very next cycle. It expects the current bit to keep the old length and the following bit to take the new one. A behavioural reference model counts cycles since acceptance and predicts every output on every clock, including the free-bus state after en drops halfway through a start. The long divisor products (up to 960 cycles per phase) are covered by running a start and a stop at the high codes.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;

    localparam int NF_CODE_W = 4;
    localparam int SC_CODE_W = 3;
    localparam int NF_CNT_W  = 6;   // holds the largest first-stage divisor (60)
    localparam int SC_CNT_W  = 10;  // holds the largest second-stage divisor (512)
    localparam int N_PHASES  = 4;
    localparam int PH_W      = $clog2(N_PHASES);

    typedef enum logic [1:0] {
        BC_START = 2'd0,
        BC_STOP  = 2'd1,
        BC_WRITE = 2'd2,
        BC_READ  = 2'd3
    } bitcmd_e;

    typedef struct packed {
        logic scl_oe;
        logic scl_o;
        logic sda_oe;
        logic sda_o;
    } drive_t;

    // first stage: powers of two for the low codes, then four times the code
    function automatic logic [NF_CNT_W-1:0] nf_divisor(input logic [NF_CODE_W-1:0] c);
        if (c < NF_CODE_W'(3))
            return NF_CNT_W'(2) << c;
        else
            return NF_CNT_W'(c) << 2;
    endfunction

    function automatic logic [SC_CNT_W-1:0] sc_divisor(input logic [SC_CODE_W-1:0] c);
        return SC_CNT_W'(4) << c;
    endfunction

endpackage

// File: rtl/i2cq_prescale.sv
module i2cq_prescale
    import i2cq_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 run,
    input  logic [NF_CODE_W-1:0] nf_code,
    input  logic [SC_CODE_W-1:0] sc_code,
    output logic                 phase_tick
);

    logic [NF_CNT_W-1:0] c1, d1m;
    logic [SC_CNT_W-1:0] c2, d2m;
    logic                nf_tick;

    assign d1m        = nf_divisor(nf_code) - NF_CNT_W'(1);
    assign d2m        = sc_divisor(sc_code) - SC_CNT_W'(1);
    assign nf_tick    = run && (c1 == d1m);
    assign phase_tick = nf_tick && (c2 == d2m);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            c1 <= '0;
            c2 <= '0;
        end else if (nf_tick) begin
            c1 <= '0;
            c2 <= (c2 == d2m) ? '0 : c2 + SC_CNT_W'(1);
        end else begin
            c1 <= c1 + NF_CNT_W'(1);
        end
    end

    p_c1_bound_r1: assert property (@(posedge clk) disable iff (rst) c1 <= d1m);
    p_c2_bound_r2: assert property (@(posedge clk) disable iff (rst) c2 <= d2m);
    p_tick_run_r1: assert property (@(posedge clk) disable iff (rst) $rose(run) |-> !phase_tick);

endmodule

// File: rtl/i2cq_phaser.sv
module i2cq_phaser
    import i2cq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_kind,
    input  logic                cmd_bit,
    input  logic                sda_in,
    input  logic                phase_tick,
    output logic                active,
    output logic                cmd_ready,
    output drive_t              drv,
    output logic [N_PHASES-1:0] phase_strobe,
    output logic                bit_done,
    output logic                rx_bit
);

    logic [PH_W-1:0] phase;
    bitcmd_e         kind;
    logic            dbit, owned, samp, accept;

    assign cmd_ready = en && !active;
    assign accept    = cmd_valid && cmd_ready;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active <= 1'b0;
            owned  <= 1'b0;
            phase  <= '0;
            kind   <= BC_WRITE;
            dbit   <= 1'b0;
            samp   <= 1'b0;
        end else if (active) begin
            if (phase_tick) begin
                if (phase == PH_W'(2) && kind == BC_READ)
                    samp <= sda_in;
                if (phase == PH_W'(N_PHASES-1)) begin
                    active <= 1'b0;
                    if (kind == BC_STOP)
                        owned <= 1'b0;
                end
                phase <= phase + PH_W'(1);
            end
        end else if (accept) begin
            active <= 1'b1;
            phase  <= '0;
            kind   <= bitcmd_e'(cmd_kind);
            dbit   <= cmd_bit;
            if (bitcmd_e'(cmd_kind) == BC_START)
                owned <= 1'b1;
        end
    end

    for (genvar k = 0; k < N_PHASES; k++) begin : g_strobe
        assign phase_strobe[k] = active && phase_tick && (phase == PH_W'(k));
    end

    assign bit_done = phase_strobe[N_PHASES-1];
    assign rx_bit   = bit_done && (kind == BC_READ) && samp;

    always_comb begin
        drv = '0;
        if (active) begin
            drv.scl_oe = 1'b1;
            if (kind == BC_STOP)
                drv.scl_o = (phase != PH_W'(0));
            else
                drv.scl_o = (phase == PH_W'(1)) || (phase == PH_W'(2));
            case (kind)
                BC_WRITE: begin drv.sda_oe = 1'b1; drv.sda_o = dbit;     end
                BC_START: begin drv.sda_oe = 1'b1; drv.sda_o = !phase[1]; end
                BC_STOP:  begin drv.sda_oe = 1'b1; drv.sda_o = phase[1];  end
                default:  begin drv.sda_oe = 1'b0; drv.sda_o = 1'b0;      end
            endcase
        end else if (owned) begin
            drv.scl_oe = 1'b1;
        end
    end

    p_scl_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (active && $past(active) && !$past(phase_tick)) |-> $stable(drv.scl_o));
    p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
        bit_done |=> !active);
    p_strobe_one_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(phase_strobe));
    p_ready_gap_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> !cmd_ready);
    p_abort_free_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!drv.scl_oe && !drv.sda_oe));

endmodule

// File: rtl/i2cq_bitgen.sv
module i2cq_bitgen
    import i2cq_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [3:0] nf_code,
    input  logic [2:0] scl_code,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_kind,
    input  logic       cmd_bit,
    output logic       cmd_ready,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       scl_out,
    output logic       sda_oe,
    output logic       sda_out,
    output logic [3:0] phase_strobe,
    output logic       bit_done,
    output logic       rx_bit
);

    logic [NF_CODE_W-1:0] nf_lat;
    logic [SC_CODE_W-1:0] sc_lat;
    logic                 busy, phase_tick;
    drive_t               drv;

    // codes follow the inputs only while no bit runs (R9)
    always_ff @(posedge clk) begin
        if (rst) begin
            nf_lat <= '0;
            sc_lat <= '0;
        end else if (!busy) begin
            nf_lat <= nf_code;
            sc_lat <= scl_code;
        end
    end

    i2cq_prescale i_prescale (
        .clk        (clk),
        .rst        (rst),
        .run        (busy),
        .nf_code    (nf_lat),
        .sc_code    (sc_lat),
        .phase_tick (phase_tick)
    );

    i2cq_phaser i_phaser (
        .clk          (clk),
        .rst          (rst),
        .en           (en),
        .cmd_valid    (cmd_valid),
        .cmd_kind     (cmd_kind),
        .cmd_bit      (cmd_bit),
        .sda_in       (sda_in),
        .phase_tick   (phase_tick),
        .active       (busy),
        .cmd_ready    (cmd_ready),
        .drv          (drv),
        .phase_strobe (phase_strobe),
        .bit_done     (bit_done),
        .rx_bit       (rx_bit)
    );

    assign scl_oe  = drv.scl_oe;
    assign scl_out = drv.scl_o;
    assign sda_oe  = drv.sda_oe;
    assign sda_out = drv.sda_o;

    p_codes_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        ($past(busy) && busy) |-> ($stable(nf_lat) && $stable(sc_lat)));

endmodule

// File: tb/test_i2cq_bitgen.sv
module test_i2cq_bitgen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0;
    logic [3:0] nf_code = '0;
    logic [2:0] scl_code = '0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_kind = '0;
    logic       cmd_bit = 1'b0;
    logic       sda_in = 1'b1;
    logic       cmd_ready, scl_oe, scl_out, sda_oe, sda_out, bit_done, rx_bit;
    logic [3:0] phase_strobe;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    logic [15:0] lf = 16'hACE1;

    always #4 clk = ~clk;

    i2cq_bitgen i_i2cq_bitgen (
        .clk(clk), .rst(rst), .en(en), .nf_code(nf_code), .scl_code(scl_code),
        .cmd_valid(cmd_valid), .cmd_kind(cmd_kind), .cmd_bit(cmd_bit),
        .cmd_ready(cmd_ready), .sda_in(sda_in), .scl_oe(scl_oe), .scl_out(scl_out),
        .sda_oe(sda_oe), .sda_out(sda_out), .phase_strobe(phase_strobe),
        .bit_done(bit_done), .rx_bit(rx_bit)
    );

    function automatic int div_a(input logic [3:0] c);
        if (c == 0) return 2;
        if (c == 1) return 4;
        if (c == 2) return 8;
        return 4 * int'(c);
    endfunction

    function automatic int div_b(input logic [2:0] c);
        int v = 4;
        for (int i = 0; i < int'(c); i++) v = v * 2;
        return v;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // behavioural reference model
    bit       m_act = 0, m_own = 0, m_samp = 0, m_b = 0;
    int       m_n = 0, m_p = 1;
    logic [1:0] m_kind = 2'd2;

    always @(negedge clk) begin
        lf <= {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        sda_in <= lf[0];
    end

    always @(posedge clk) begin
        if (rst || !en) begin
            m_act = 0; m_own = 0; m_samp = 0;
        end else if (m_act) begin
            if ((m_n % m_p) == m_p - 1 && (m_n / m_p) == 2 && m_kind == 2'd3)
                m_samp = sda_in;
            if (m_n == 4 * m_p - 1) begin
                m_act = 0;
                if (m_kind == 2'd1) m_own = 0;
            end else m_n++;
        end else if (cmd_valid) begin
            m_act = 1; m_n = 0; m_p = div_a(nf_code) * div_b(scl_code);
            m_kind = cmd_kind; m_b = cmd_bit;
            if (cmd_kind == 2'd0) m_own = 1;
        end
    end

    always @(posedge clk) begin
        #1;
        if (!finished) begin
            int ph; bit last;
            bit e_scl_oe, e_scl, e_sda_oe, e_sda, e_done, e_rx;
            logic [3:0] e_str;
            string ts, td;
            ph = m_n / m_p;
            last = m_act && ((m_n % m_p) == m_p - 1);
            e_scl_oe = m_act || m_own;
            e_scl = m_act && ((m_kind == 2'd1) ? (ph != 0) : (ph == 1 || ph == 2));
            e_sda_oe = m_act && (m_kind != 2'd3);
            e_sda = 0;
            if (m_act) begin
                case (m_kind)
                    2'd0: e_sda = (ph < 2);
                    2'd1: e_sda = (ph >= 2);
                    2'd2: e_sda = m_b;
                    default: e_sda = 0;
                endcase
            end
            e_str = last ? (4'b0001 << ph) : 4'b0000;
            e_done = last && ph == 3;
            e_rx = e_done && m_kind == 2'd3 && m_samp;
            ts = m_act ? "R3" : (m_own ? "R5" : "R4");
            td = m_act ? ((m_kind[1]) ? "R6" : "R7") : (m_own ? "R5" : "R4");
            chk(scl_oe == e_scl_oe, ts, scl_oe, e_scl_oe);
            chk(scl_out == e_scl, ts, scl_out, e_scl);
            chk(sda_oe == e_sda_oe, td, sda_oe, e_sda_oe);
            chk(sda_out == e_sda, td, sda_out, e_sda);
            chk(phase_strobe == e_str, "R8", phase_strobe, e_str);
            chk(bit_done == e_done, "R8", bit_done, e_done);
            chk(rx_bit == e_rx, "R6", rx_bit, e_rx);
            chk(cmd_ready == (en && !m_act), "R10", cmd_ready, en && !m_act);
        end
    end

    // issue one bit; optionally change the codes right after acceptance
    task automatic do_bit(input logic [1:0] k, input bit b, input string tag,
                          input bit chg, input logic [3:0] nn, input logic [2:0] ns);
        int len, exp;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        exp = 4 * div_a(nf_code) * div_b(scl_code);
        cmd_valid = 1; cmd_kind = k; cmd_bit = b;
        @(negedge clk);
        cmd_valid = 0;
        if (chg) begin nf_code = nn; scl_code = ns; end
        len = 1;
        while (!bit_done) begin @(negedge clk); len++; end
        chk(len == exp, tag, len, exp);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            bad++; total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R11: reset state
        chk({scl_oe, scl_out, sda_oe, sda_out, bit_done, rx_bit} == 6'b0, "R11",
            {scl_oe, scl_out, sda_oe, sda_out, bit_done, rx_bit}, 0);
        chk(phase_strobe == 4'b0, "R11", phase_strobe, 0);
        rst = 0; en = 1;
        @(negedge clk);
        // fastest setting: 2*4 cycles per phase (R1)
        do_bit(2'd0, 0, "R1", 0, 0, 0);
        do_bit(2'd2, 1, "R1", 0, 0, 0);
        do_bit(2'd2, 0, "R1", 0, 0, 0);
        do_bit(2'd3, 0, "R6", 0, 0, 0);
        do_bit(2'd3, 0, "R6", 0, 0, 0);
        do_bit(2'd1, 0, "R7", 0, 0, 0);
        repeat (5) @(negedge clk);
        chk(!scl_oe && !sda_oe, "R4", {scl_oe, sda_oe}, 0);
        // first stage code 1 and a multiple-of-four code
        nf_code = 4'd1;
        do_bit(2'd0, 0, "R1", 0, 0, 0);
        do_bit(2'd2, 1, "R1", 0, 0, 0);
        repeat (3) @(negedge clk);
        chk(scl_oe && !scl_out && !sda_oe, "R5", {scl_oe, scl_out, sda_oe}, 3'b100);
        do_bit(2'd1, 0, "R1", 0, 0, 0);
        nf_code = 4'd3; scl_code = 3'd1;
        do_bit(2'd0, 0, "R2", 0, 0, 0);
        do_bit(2'd3, 0, "R2", 0, 0, 0);
        do_bit(2'd1, 0, "R2", 0, 0, 0);
        nf_code = 4'd15; scl_code = 3'd2;
        do_bit(2'd0, 0, "R1", 0, 0, 0);
        do_bit(2'd1, 0, "R1", 0, 0, 0);
        nf_code = 4'd2; scl_code = 3'd3;
        do_bit(2'd0, 0, "R2", 0, 0, 0);
        do_bit(2'd2, 1, "R2", 0, 0, 0);
        do_bit(2'd1, 0, "R2", 0, 0, 0);
        // R9: codes changed one cycle after acceptance
        nf_code = 4'd0; scl_code = 3'd0;
        do_bit(2'd0, 0, "R9", 1, 4'd5, 3'd2);
        do_bit(2'd2, 1, "R9", 0, 0, 0);
        do_bit(2'd1, 0, "R9", 0, 0, 0);
        // R10: abort in the middle of a start
        nf_code = 4'd0; scl_code = 3'd0;
        @(negedge clk);
        while (!cmd_ready) @(negedge clk);
        cmd_valid = 1; cmd_kind = 2'd0;
        @(negedge clk);
        cmd_valid = 0;
        repeat (12) @(negedge clk);
        en = 0;
        @(negedge clk);
        chk(!scl_oe && !sda_oe && !cmd_ready, "R10", {scl_oe, sda_oe, cmd_ready}, 0);
        @(negedge clk);
        en = 1;
        @(negedge clk);
        chk(!scl_oe && cmd_ready, "R10", {scl_oe, cmd_ready}, 1);
        do_bit(2'd0, 0, "R1", 0, 0, 0);
        do_bit(2'd1, 0, "R7", 0, 0, 0);
        repeat (4) @(negedge clk);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule